// File: doc/BRIEF.md
# Frame-Locked Stretch/Shrink Digital PLL

This block produces a line-rate clock and an internal 8 kHz frame signal from a master-rate timebase, and keeps them in phase with an external 8 kHz reference. The master clock is represented by a tick enable that pulses at twice the master rate, so one master period normally spans two ticks. A divide-by-8 stage turns master periods into the line clock. A divide-by-N stage (N = 193 for a 1.544 MHz line, N = 256 for a 2.048 MHz line) turns line periods into the frame signal. The same divider decodes a correction-window signal that is low for a short span centred on the frame signal's falling edge.

Every falling edge of the reference is synchronised and then used to take a single snapshot of the frame signal and the window signal. A snapshot taken inside the window changes nothing. A snapshot taken outside the window schedules a correction of half a master period. The correction is either one extra tick, which stretches the master clock, or one skipped tick, which shrinks it. It is applied once, at the next master-period boundary, and it moves all divider outputs together. A free-run control stops all tracking. The block has no data stream: every pin is a plain level or a clock-rate enable, with no handshake and no back-pressure.

Top module: `frame_lock_dpll`

## Requirements
- R1: `line_clk` is the master count divided by 8. It is high for master positions 0..3 and low for positions 4..7 of each group of eight master periods.
- R2: `frame_8k` has a period of 8·N master periods. It is high for frame positions 0 .. 4N−1 and low for positions 4N .. 8N−1, where the frame position counts master periods from 0.
- R3: `cs_win` is low exactly for frame positions 4N − W/2 .. 4N + W/2 − 1 and high elsewhere. W is 4 master periods when N = 193 and 512 when N = 256. The falling edge of `frame_8k` therefore lies inside the low span.
- R4: `ref_8k` passes through a two-flop synchroniser and a falling-edge detector, so each reference falling edge yields exactly one snapshot. A snapshot with `cs_win` = 0 causes no correction.
- R5: A snapshot with `cs_win` = 1 and `frame_8k` = 0 stretches the master clock by half a period: one extra tick before the next master-period boundary.
- R6: A snapshot with `cs_win` = 1 and `frame_8k` = 1 shrinks the master clock by half a period: one tick is skipped at the next master-period boundary.
- R7: While `free_run` is 1, reference edges cause no correction.
- R8: The dividers advance only on `tick2x_en`. Without a correction, each master period takes exactly two ticks, and all outputs hold while the enable is low.
- R9: An active-low `rst_n` clears all counters and any pending correction. In reset, `line_clk`, `frame_8k` and `cs_win` read 1. After release, the first `frame_8k` fall comes after exactly 8N ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick2x_en | input | 1 | Enable pulsing at twice the master-clock rate |
| ref_8k | input | 1 | 8 kHz reference; its falling edge is the phase sample point |
| free_run | input | 1 | 1 = never correct, run from the master timebase only |
| line_clk | output | 1 | Line-rate clock (master / 8) |
| frame_8k | output | 1 | Internal 8 kHz signal (line / N) |
| cs_win | output | 1 | Correction-window signal, low inside the no-correction span |

## Verification
A reference falling edge driven between clock edges reaches the snapshot register on the third rising edge after it. The pending correction then lands on the first later tick that starts a master period. The outputs are decoded from the counter registers, so each one changes on the rising edge that advances the divider. With the enable high on every cycle, the bench computes the frame position that will be sampled for each reference timing, and checks the result as the span between two later falling edges of `frame_8k`: 6176 cycles, plus or minus one. The measurement brackets the correction, so its exact landing cycle does not matter, while the window boundaries are still hit exactly. Reset and divider checks count negative edges from the release or from the enable turning on, and compare the counts with the tick arithmetic in R1, R2, R3, R8 and R9.

// File: rtl/fldpll_pkg.sv
`timescale 1ns/1ps
package fldpll_pkg;

  typedef enum logic [1:0] {
    CORR_NONE    = 2'd0,
    CORR_STRETCH = 2'd1,
    CORR_SHRINK  = 2'd2
  } corr_e;

  // Width of the no-correction span in master periods for a given frame divisor.
  function automatic int nocorr_span(input int div_n);
    return (div_n == 256) ? 512 : 4;
  endfunction

endpackage

// File: rtl/fldpll_ref_edge.sv
`timescale 1ns/1ps
module fldpll_ref_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_i,
  output logic fall_o
);

  localparam int DEPTH = SYNC_STAGES + 1;

  logic [DEPTH-1:0] shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '1;
    else        shift_q <= {shift_q[DEPTH-2:0], ref_i};
  end

  // Last synchroniser stage is low while the delayed copy is still high.
  assign fall_o = shift_q[DEPTH-1] & ~shift_q[DEPTH-2];

  // R4: one decision per reference edge
  assert_one_decision_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o)
    else $error("reference edge produced two consecutive samples");

endmodule

// File: rtl/fldpll_phase_cmp.sv
`timescale 1ns/1ps
module fldpll_phase_cmp
  import fldpll_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  fall_i,
  input  logic  free_run_i,
  input  logic  frame_i,
  input  logic  cs_i,
  output logic  req_o,
  output corr_e kind_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_o  <= 1'b0;
      kind_o <= CORR_NONE;
    end else begin
      req_o <= fall_i & ~free_run_i & cs_i;
      if (fall_i) kind_o <= frame_i ? CORR_SHRINK : CORR_STRETCH;
    end
  end

  // R7: free-run suppresses every request
  assert_freerun_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    free_run_i |=> !req_o)
    else $error("correction requested in free-run");

  // R4: a request only follows a detected edge
  assert_req_after_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_i |=> !req_o)
    else $error("request without reference edge");

endmodule

// File: rtl/fldpll_tick_corr.sv
`timescale 1ns/1ps
module fldpll_tick_corr
  import fldpll_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick_i,
  input  logic  req_i,
  input  corr_e kind_i,
  output logic  adv_o
);

  logic  half_q, half_d;
  corr_e pend_q;
  logic  apply;

  // half_q = 0: next tick opens a master period, the only point where a correction lands.
  always_comb begin
    adv_o  = 1'b0;
    half_d = half_q;
    apply  = 1'b0;
    if (tick_i) begin
      if (half_q) begin
        adv_o  = 1'b1;
        half_d = 1'b0;
      end else if (pend_q == CORR_STRETCH) begin
        apply  = 1'b1;            // extra tick: stay in first half
      end else if (pend_q == CORR_SHRINK) begin
        adv_o  = 1'b1;            // skip second half
        apply  = 1'b1;
      end else begin
        half_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= 1'b0;
      pend_q <= CORR_NONE;
    end else begin
      half_q <= half_d;
      if (req_i)      pend_q <= kind_i;
      else if (apply) pend_q <= CORR_NONE;
    end
  end

  // R5 and R6: a pending correction is consumed at the first period boundary
  assert_pend_applied_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q != CORR_NONE && tick_i && !half_q && !req_i) |=> (pend_q == CORR_NONE))
    else $error("pending correction not applied");

  // R8: no advance without a tick
  assert_adv_needs_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(half_q))
    else $error("half-phase moved without tick");

endmodule

// File: rtl/fldpll_divider.sv
`timescale 1ns/1ps
module fldpll_divider #(
  parameter int PRE_DIV   = 8,
  parameter int DIV_N     = 193,
  parameter int NOCORR_MP = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv_i,
  output logic line_clk_o,
  output logic frame_o,
  output logic cs_o
);

  localparam int FRAME_MP = PRE_DIV * DIV_N;
  localparam int EDGE_MP  = FRAME_MP / 2;
  localparam int WIN_LO   = EDGE_MP - NOCORR_MP / 2;
  localparam int WIN_HI   = EDGE_MP + NOCORR_MP / 2;
  localparam int MW       = $clog2(PRE_DIV);
  localparam int FW       = $clog2(DIV_N);
  localparam int PW       = $clog2(FRAME_MP);
  localparam bit POW2     = (PRE_DIV & (PRE_DIV - 1)) == 0;

  logic [MW-1:0] m_q;
  logic [FW-1:0] f_q;
  logic [PW-1:0] pos;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q <= '0;
      f_q <= '0;
    end else if (adv_i) begin
      if (m_q == MW'(PRE_DIV - 1)) begin
        m_q <= '0;
        f_q <= (f_q == FW'(DIV_N - 1)) ? '0 : f_q + 1'b1;
      end else begin
        m_q <= m_q + 1'b1;
      end
    end
  end

  generate
    if (POW2) begin : g_concat
      assign pos = PW'({f_q, m_q});
    end else begin : g_mul
      assign pos = PW'(f_q) * PW'(PRE_DIV) + PW'(m_q);
    end
  endgenerate

  assign line_clk_o = (m_q < MW'(PRE_DIV / 2));
  assign frame_o    = (pos < PW'(EDGE_MP));
  assign cs_o       = !((pos >= PW'(WIN_LO)) && (pos < PW'(WIN_HI)));

  // R8: counters hold while no advance
  assert_hold_without_adv_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_i |=> ($stable(m_q) && $stable(f_q)))
    else $error("divider moved without advance");

  // R3: frame edge lies inside the no-correction span
  assert_edge_in_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frame_o) |-> !cs_o)
    else $error("frame edge outside window");

  // R2: frame counter stays within its divisor
  assert_frame_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(f_q) < DIV_N)
    else $error("frame counter out of range");

endmodule

// File: rtl/frame_lock_dpll.sv
`timescale 1ns/1ps
module frame_lock_dpll #(
  parameter int DIV_N       = 193,
  parameter int PRE_DIV     = 8,
  parameter int NOCORR_MP   = fldpll_pkg::nocorr_span(DIV_N),
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick2x_en,
  input  logic ref_8k,
  input  logic free_run,
  output logic line_clk,
  output logic frame_8k,
  output logic cs_win
);
  import fldpll_pkg::*;

  logic  ref_fall;
  logic  corr_req;
  corr_e corr_kind;
  logic  advance;

  fldpll_ref_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .ref_i  (ref_8k),
    .fall_o (ref_fall)
  );

  fldpll_phase_cmp u_cmp (
    .clk        (clk),
    .rst_n      (rst_n),
    .fall_i     (ref_fall),
    .free_run_i (free_run),
    .frame_i    (frame_8k),
    .cs_i       (cs_win),
    .req_o      (corr_req),
    .kind_o     (corr_kind)
  );

  fldpll_tick_corr u_corr (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (tick2x_en),
    .req_i  (corr_req),
    .kind_i (corr_kind),
    .adv_o  (advance)
  );

  fldpll_divider #(
    .PRE_DIV   (PRE_DIV),
    .DIV_N     (DIV_N),
    .NOCORR_MP (NOCORR_MP)
  ) u_div (
    .clk        (clk),
    .rst_n      (rst_n),
    .adv_i      (advance),
    .line_clk_o (line_clk),
    .frame_o    (frame_8k),
    .cs_o       (cs_win)
  );

  // R1: line clock falls only at a divider advance
  assert_line_fall_on_adv_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> !$fell(line_clk))
    else $error("line clock fell without advance");

endmodule

// File: tb/frame_lock_dpll_tb_top.sv
`timescale 1ns/1ps
module frame_lock_dpll_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick2x_en = 1'b1;
  logic ref_8k = 1'b1;
  logic free_run = 1'b0;
  logic line_clk, frame_8k, cs_win;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  frame_lock_dpll dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick2x_en (tick2x_en),
    .ref_8k    (ref_8k),
    .free_run  (free_run),
    .line_clk  (line_clk),
    .frame_8k  (frame_8k),
    .cs_win    (cs_win)
  );

  // N = 193: frame = 1544 master periods = 3088 ticks; two frames = 6176.
  localparam int NV = 10;
  // delay (cycles after frame fall) of the reference fall; 0 = no reference edge
  localparam int VD [NV] = '{0,    1000, 2000, 3084, 3080, 3082, 3088, 3090, 1000, 2000};
  localparam int VF [NV] = '{0,    0,    0,    0,    0,    0,    0,    0,    1,    1};
  localparam int VX [NV] = '{0,    1,    -1,   0,    -1,   0,    0,    1,    0,    0};
  // tags: R2, R5, R6, R4, R6, R3, R3, R5, R7, R7
  localparam int VQ [NV] = '{2,    5,    6,    4,    6,    3,    3,    5,    7,    7};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic run_vec(input int idx);
    int c = 0;
    int falls = 0;
    bit prev;
    free_run = VF[idx];
    prev = frame_8k;
    forever begin
      @(negedge clk);
      if (prev && !frame_8k) break;
      prev = frame_8k;
    end
    prev = frame_8k;
    while (falls < 2 && c < 10000) begin
      @(negedge clk);
      c++;
      if (prev && !frame_8k) falls++;
      prev = frame_8k;
      if (VD[idx] != 0 && c == VD[idx])      ref_8k = 1'b0;
      if (VD[idx] != 0 && c == VD[idx] + 20) ref_8k = 1'b1;
    end
    ref_8k = 1'b1;
    if (c != 6176 + VX[idx])
      $display("vector %0d tag R%0d", idx, VQ[idx]);
    check(c == 6176 + VX[idx], $sformatf("R%0d vector %0d two-frame span", VQ[idx], idx),
          c, 6176 + VX[idx]);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    finish_run();
  end

  initial begin
    int t_line1 = -1, t_line2 = -1, t_csf = -1, t_fr = -1, t_csr = -1;
    bit pl, pc, pf;

    // R9: reset state
    repeat (3) @(negedge clk);
    check(line_clk == 1'b1, "R9 line_clk in reset", line_clk, 1);
    check(frame_8k == 1'b1, "R9 frame_8k in reset", frame_8k, 1);
    check(cs_win   == 1'b1, "R9 cs_win in reset",   cs_win,   1);

    rst_n = 1'b1;
    pl = line_clk; pc = cs_win; pf = frame_8k;
    for (int c = 1; c <= 1600; c++) begin
      @(negedge clk);
      if (pl && !line_clk) begin
        if (t_line1 < 0) t_line1 = c;
        else if (t_line2 < 0) t_line2 = c;
      end
      if (pc && !cs_win && t_csf < 0) t_csf = c;
      if (!pc && cs_win && t_csr < 0) t_csr = c;
      if (pf && !frame_8k && t_fr < 0) t_fr = c;
      pl = line_clk; pc = cs_win; pf = frame_8k;
    end
    check(t_line1 == 8,  "R1 first line_clk fall", t_line1, 8);
    check(t_line2 - t_line1 == 16, "R1 line_clk period", t_line2 - t_line1, 16);
    check(t_csf == 1540, "R3 window opens", t_csf, 1540);
    check(t_fr  == 1544, "R2 first frame fall", t_fr, 1544);
    check(t_csr - t_csf == 8, "R3 window width", t_csr - t_csf, 8);

    // Table walk
    for (int i = 0; i < NV; i++) run_vec(i);
    free_run = 1'b0;

    // R9: pending correction cleared by reset; R8: hold without ticks
    @(negedge clk);
    tick2x_en = 1'b0;
    ref_8k = 1'b0;
    repeat (6) @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(frame_8k == 1'b1 && cs_win == 1'b1 && line_clk == 1'b1,
          "R9 outputs after mid-run reset", {line_clk, frame_8k, cs_win}, 7);
    ref_8k = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (100) @(negedge clk);
    check(frame_8k == 1'b1 && cs_win == 1'b1 && line_clk == 1'b1,
          "R8 outputs hold without tick", {line_clk, frame_8k, cs_win}, 7);
    tick2x_en = 1'b1;
    begin
      int c = 0;
      bit p = frame_8k;
      while (c < 5000) begin
        @(negedge clk);
        c++;
        if (p && !frame_8k) break;
        p = frame_8k;
      end
      check(c == 1544, "R9 first frame fall after reset with cleared pending", c, 1544);
    end

    finish_run();
  end

endmodule